// File: doc/BRIEF.md
# Data Cache Touch Prefetch Controller

This block turns a software prefetch hint into a data cache line fill. It takes one hint at a time, along with the result of address translation and the page attributes for its effective address. There are two forms of the hint, a plain touch and a touch-for-store, and both behave the same way. If the page may not be prefetched, the hint ends quietly as a no-op. If the line is already resident, only the usage bookkeeping is refreshed. Otherwise the block requests a bus read for the line-aligned address and holds that request until the response arrives. It then writes the returned line into the cache in a MESI state chosen from the snoop shared response.

Address translation, the cache array and bus arbitration are outside this block. They appear only as plain ports: attribute inputs, a residency input, a bus read request/response pair, a fill write port and three one-cycle bookkeeping strobes.

Top module: `prefetchHintTop`

## Requirements
- R1: While reset is asserted and in the first cycle after it, hintReady is 1 and busReq, fillWe, hintDone, refSet, lruTouch and tlbLruTouch are all 0.
- R2: The level of hintForStore has no effect on any output. A touch-for-store hint yields the same outputs, cycle for cycle, as a plain touch with the same other inputs.
- R3: busReq rises in the cycle after a hint is accepted only if all of these hold: xlateHit is 1, loadAllowed is 1, directStore is 0, cacheable is 1 and lineResident is 0. lineAddr then equals hintAddr with its low log2(LINE_BYTES) bits cleared.
- R4: If any one of those four page conditions fails, the hint completes with hintDone one cycle after acceptance. That hint never raises busReq, fillWe, refSet, lruTouch or tlbLruTouch.
- R5: One cycle after busRespValid is sampled high during a pending request, fillWe pulses for one cycle. In that cycle fillData equals busRespData and fillState is Exclusive (2'b10) if busRespShared was 0, or Shared (2'b01) if it was 1.
- R6: Every successful hint, whether it needed a fill or found the line resident, pulses refSet, lruTouch and tlbLruTouch together for exactly one cycle, in its completion cycle.
- R7: A qualifying hint with lineResident at 1 raises no busReq and no fillWe. It completes one cycle after acceptance with hintDone and the bookkeeping strobes.
- R8: A hint is accepted only when hintValid and hintReady are both 1. hintReady is 0 from the cycle after acceptance through the completion cycle, and a hintValid held during that time has no effect.
- R9: Each accepted hint produces exactly one hintDone pulse, lasting one cycle. For a fill, that pulse is in the same cycle as fillWe.
- R10: busReq, once raised, stays at 1 with lineAddr unchanged until busRespValid is sampled. A busRespValid with no pending request is ignored and causes no fill and no completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hintValid | input | 1 | Hint request present |
| hintForStore | input | 1 | 1 = touch-for-store form, 0 = plain touch |
| hintAddr | input | ADDR_W | Translated address of the hint |
| xlateHit | input | 1 | Translation hit in page table cache or block translation |
| loadAllowed | input | 1 | Page grants load access |
| directStore | input | 1 | Access targets a direct-store segment |
| cacheable | input | 1 | Page is cacheable |
| lineResident | input | 1 | Cache lookup found the line already valid |
| hintReady | output | 1 | Controller can accept a hint |
| hintDone | output | 1 | One-cycle completion pulse |
| busReq | output | 1 | Bus line read request, held until response |
| busRespValid | input | 1 | Bus read data returned |
| busRespShared | input | 1 | Snoop response: another agent holds the line |
| busRespData | input | LINE_BYTES*8 | Returned line data |
| lineAddr | output | ADDR_W | Line-aligned address for bus, fill and bookkeeping |
| fillWe | output | 1 | Cache fill write strobe |
| fillData | output | LINE_BYTES*8 | Line written on fill |
| fillState | output | 2 | MESI state for the fill (01 Shared, 10 Exclusive) |
| refSet | output | 1 | Set the page reference bit |
| lruTouch | output | 1 | Update cache replacement state |
| tlbLruTouch | output | 1 | Update translation cache replacement state |

## Verification
The hardest cases to reach from the ports are the ones during the bus wait. These are a second hint presented while a fill is pending, and a response that arrives with no request outstanding. The stimulus holds hintValid with a different address through a multi-cycle bus delay and checks that busReq and lineAddr do not move. It also checks that exactly one completion follows. A separate step pulses busRespValid while idle and confirms that no fill or completion appears, and that the next real fill carries only its own response data.

// File: rtl/prefetchHintPkg.sv
package prefetchHintPkg;

  // MESI encoding used on the fill port
  typedef enum logic [1:0] {
    MESI_INVALID = 2'd0,
    MESI_SHARED  = 2'd1,
    MESI_EXCL    = 2'd2,
    MESI_MOD     = 2'd3
  } mesi_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_FILL,
    ST_HIT,
    ST_NOOP
  } hintState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic capReq;     // latch the request address
    logic capResp;    // latch bus response data and snoop result
    logic writeFill;  // present the latched line on the fill port
  } pathCtl_t;

endpackage

// File: rtl/prefetchHintQualify.sv
module prefetchHintQualify (
  input  logic hintForStore,
  input  logic xlateHit,
  input  logic loadAllowed,
  input  logic directStore,
  input  logic cacheable,
  output logic eligible
);

  logic loadLike;

  // Both hint forms are checked against load permission.
  always_comb begin
    case (hintForStore)
      1'b0:    loadLike = 1'b1;
      1'b1:    loadLike = 1'b1;
      default: loadLike = 1'b1;
    endcase
  end

  always_comb begin
    eligible = xlateHit & (loadLike & loadAllowed) & ~directStore & cacheable;
  end

endmodule

// File: rtl/prefetchHintCtrl.sv
module prefetchHintCtrl
  import prefetchHintPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     hintValid,
  input  logic     eligible,
  input  logic     lineResident,
  input  logic     busRespValid,
  output logic     hintReady,
  output logic     hintDone,
  output logic     busReq,
  output logic     fillWe,
  output logic     refSet,
  output logic     lruTouch,
  output logic     tlbLruTouch,
  output pathCtl_t pathCtl
);

  hintState_e state, stateNext;
  logic accept;

  assign accept = hintValid && (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (hintValid) begin
          if (!eligible)         stateNext = ST_NOOP;
          else if (lineResident) stateNext = ST_HIT;
          else                   stateNext = ST_FETCH;
        end
      end
      ST_FETCH: if (busRespValid) stateNext = ST_FILL;
      ST_FILL:  stateNext = ST_IDLE;
      ST_HIT:   stateNext = ST_IDLE;
      ST_NOOP:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  logic successDone;
  assign successDone = (state == ST_FILL) || (state == ST_HIT);

  always_comb begin
    hintReady   = (state == ST_IDLE);
    busReq      = (state == ST_FETCH);
    fillWe      = (state == ST_FILL);
    hintDone    = successDone || (state == ST_NOOP);
    refSet      = successDone;
    lruTouch    = successDone;
    tlbLruTouch = successDone;
    pathCtl.capReq    = accept;
    pathCtl.capResp   = (state == ST_FETCH) && busRespValid;
    pathCtl.writeFill = (state == ST_FILL);
  end

  // R9: completion is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    hintDone |=> !hintDone);

  // R8: no new hint accepted while a fill is pending
  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !hintReady);

  // R10: request held until a response is seen
  a_r10_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busRespValid) |=> busReq);

  // R5: a fill follows a response to a pending request
  a_r5_fill_after_resp: assert property (@(posedge clk) disable iff (!rstN)
    fillWe |-> ($past(busRespValid) && $past(busReq)));

  // R9: fill and completion coincide
  a_r9_fill_with_done: assert property (@(posedge clk) disable iff (!rstN)
    fillWe |-> hintDone);

  // R4: a quiet completion never touches bus or cache
  a_r4_noop_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (hintDone && !refSet) |-> (!fillWe && !busReq && !lruTouch && !tlbLruTouch));

  // R6: bookkeeping strobes only at completion
  a_r6_ref_at_done: assert property (@(posedge clk) disable iff (!rstN)
    (refSet || lruTouch || tlbLruTouch) |-> hintDone);

endmodule

// File: rtl/prefetchHintPath.sv
module prefetchHintPath
  import prefetchHintPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  pathCtl_t                pathCtl,
  input  logic                    busReq,
  input  logic [ADDR_W-1:0]       hintAddr,
  input  logic                    busRespShared,
  input  logic [LINE_BYTES*8-1:0] busRespData,
  output logic [ADDR_W-1:0]       lineAddr,
  output logic [LINE_BYTES*8-1:0] fillData,
  output logic [1:0]              fillState
);

  localparam int OFFS_W  = $clog2(LINE_BYTES);
  localparam int LINE_W  = LINE_BYTES * 8;
  localparam int LANE_W  = 32;
  localparam int N_LANES = (LINE_W + LANE_W - 1) / LANE_W;

  logic [ADDR_W-1:0] addrQ;
  logic              sharedQ;
  logic [LINE_W-1:0] dataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      sharedQ <= 1'b0;
    end else begin
      if (pathCtl.capReq)  addrQ   <= {hintAddr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};
      if (pathCtl.capResp) sharedQ <= busRespShared;
    end
  end

  // Response line captured in 32-bit lanes
  for (genvar g = 0; g < N_LANES; g++) begin : gLane
    localparam int LO = g * LANE_W;
    localparam int HI = ((g + 1) * LANE_W > LINE_W) ? LINE_W - 1 : (g + 1) * LANE_W - 1;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                dataQ[HI:LO] <= '0;
      else if (pathCtl.capResp) dataQ[HI:LO] <= busRespData[HI:LO];
    end
  end

  always_comb begin
    lineAddr  = addrQ;
    fillData  = pathCtl.writeFill ? dataQ : '0;
    fillState = pathCtl.writeFill ? (sharedQ ? MESI_SHARED : MESI_EXCL) : MESI_INVALID;
  end

  // R10: address seen by the bus does not move while the request is held
  a_r10_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && $past(busReq)) |-> $stable(lineAddr));

  // R3: address is always line aligned
  a_r3_addr_aligned: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (lineAddr[OFFS_W-1:0] == '0));

  // R5: fill state is never invalid or modified on a fill write
  a_r5_state_legal: assert property (@(posedge clk) disable iff (!rstN)
    pathCtl.writeFill |-> (fillState == MESI_SHARED || fillState == MESI_EXCL));

endmodule

// File: rtl/prefetchHintTop.sv
module prefetchHintTop
  import prefetchHintPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hintValid,
  input  logic                    hintForStore,
  input  logic [ADDR_W-1:0]       hintAddr,
  input  logic                    xlateHit,
  input  logic                    loadAllowed,
  input  logic                    directStore,
  input  logic                    cacheable,
  input  logic                    lineResident,
  output logic                    hintReady,
  output logic                    hintDone,
  output logic                    busReq,
  input  logic                    busRespValid,
  input  logic                    busRespShared,
  input  logic [LINE_BYTES*8-1:0] busRespData,
  output logic [ADDR_W-1:0]       lineAddr,
  output logic                    fillWe,
  output logic [LINE_BYTES*8-1:0] fillData,
  output logic [1:0]              fillState,
  output logic                    refSet,
  output logic                    lruTouch,
  output logic                    tlbLruTouch
);

  logic     eligible;
  pathCtl_t pathCtl;

  prefetchHintQualify uQualify (
    .hintForStore (hintForStore),
    .xlateHit     (xlateHit),
    .loadAllowed  (loadAllowed),
    .directStore  (directStore),
    .cacheable    (cacheable),
    .eligible     (eligible)
  );

  prefetchHintCtrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .hintValid    (hintValid),
    .eligible     (eligible),
    .lineResident (lineResident),
    .busRespValid (busRespValid),
    .hintReady    (hintReady),
    .hintDone     (hintDone),
    .busReq       (busReq),
    .fillWe       (fillWe),
    .refSet       (refSet),
    .lruTouch     (lruTouch),
    .tlbLruTouch  (tlbLruTouch),
    .pathCtl      (pathCtl)
  );

  prefetchHintPath #(
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
  ) uPath (
    .clk           (clk),
    .rstN          (rstN),
    .pathCtl       (pathCtl),
    .busReq        (busReq),
    .hintAddr      (hintAddr),
    .busRespShared (busRespShared),
    .busRespData   (busRespData),
    .lineAddr      (lineAddr),
    .fillData      (fillData),
    .fillState     (fillState)
  );

endmodule

// File: tb/prefetchHintTop_test.sv
module prefetchHintTop_test;

  localparam int ADDR_W     = 32;
  localparam int LINE_BYTES = 32;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~(ADDR_W'(LINE_BYTES) - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hintValid = 1'b0, hintForStore = 1'b0;
  logic [ADDR_W-1:0] hintAddr = '0;
  logic xlateHit = 1'b0, loadAllowed = 1'b0, directStore = 1'b0, cacheable = 1'b0;
  logic lineResident = 1'b0;
  logic busRespValid = 1'b0, busRespShared = 1'b0;
  logic [LINE_W-1:0] busRespData = '0;
  logic hintReady, hintDone, busReq, fillWe, refSet, lruTouch, tlbLruTouch;
  logic [ADDR_W-1:0] lineAddr;
  logic [LINE_W-1:0] fillData;
  logic [1:0] fillState;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  prefetchHintTop #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) uut (
    .clk(clk), .rstN(rstN), .hintValid(hintValid), .hintForStore(hintForStore),
    .hintAddr(hintAddr), .xlateHit(xlateHit), .loadAllowed(loadAllowed),
    .directStore(directStore), .cacheable(cacheable), .lineResident(lineResident),
    .hintReady(hintReady), .hintDone(hintDone), .busReq(busReq),
    .busRespValid(busRespValid), .busRespShared(busRespShared), .busRespData(busRespData),
    .lineAddr(lineAddr), .fillWe(fillWe), .fillData(fillData), .fillState(fillState),
    .refSet(refSet), .lruTouch(lruTouch), .tlbLruTouch(tlbLruTouch)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] lineFor(input logic [ADDR_W-1:0] a);
    return {(LINE_W/32){32'hC0DE0000 ^ a}};
  endfunction

  // Outputs that must be quiet in idle
  task automatic chkIdle(input string req);
    chk(hintReady == 1'b1, req, "hintReady idle", 64'(hintReady), 1);
    chk({hintDone, busReq, fillWe, refSet, lruTouch, tlbLruTouch} == 6'b0, req,
        "strobes idle", 64'({hintDone, busReq, fillWe, refSet, lruTouch, tlbLruTouch}), 0);
  endtask

  // Present one hint; returns at the negedge after the accepting edge
  task automatic acceptHint(input logic [ADDR_W-1:0] a, input logic fs, input logic hit,
                            input logic ld, input logic ds, input logic cach, input logic res);
    @(negedge clk);
    hintValid = 1'b1; hintForStore = fs; hintAddr = a;
    xlateHit = hit; loadAllowed = ld; directStore = ds; cacheable = cach; lineResident = res;
    chk(hintReady == 1'b1, "R8", "ready before accept", 64'(hintReady), 1);
    @(posedge clk);
    @(negedge clk);
    hintValid = 1'b0;
  endtask

  task automatic testNoop(input logic hit, input logic ld, input logic ds, input logic cach,
                          input logic fs);
    acceptHint(32'h0000_4A64, fs, hit, ld, ds, cach, 1'b0);
    // R4: quiet completion one cycle after accept
    chk(hintDone == 1'b1, "R4", "noop done", 64'(hintDone), 1);
    chk({busReq, fillWe, refSet, lruTouch, tlbLruTouch} == 5'b0, "R4", "noop quiet",
        64'({busReq, fillWe, refSet, lruTouch, tlbLruTouch}), 0);
    chk(hintReady == 1'b0, "R8", "noop busy", 64'(hintReady), 0);
    @(negedge clk);
    chk(hintDone == 1'b0, "R9", "noop done single", 64'(hintDone), 0);
    chkIdle("R4");
  endtask

  task automatic testResident(input logic fs);
    acceptHint(32'h0001_0038, fs, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    // R7 / R6: resident line completes with bookkeeping, no bus
    chk({busReq, fillWe} == 2'b0, "R7", "resident no bus/fill", 64'({busReq, fillWe}), 0);
    chk({hintDone, refSet, lruTouch, tlbLruTouch} == 4'hF, "R6", "resident bookkeeping",
        64'({hintDone, refSet, lruTouch, tlbLruTouch}), 64'hF);
    chk(lineAddr == 32'h0001_0020, "R7", "resident lineAddr", 64'(lineAddr), 64'h0001_0020);
    @(negedge clk);
    chk({refSet, lruTouch, tlbLruTouch} == 3'b0, "R6", "bookkeeping single",
        64'({refSet, lruTouch, tlbLruTouch}), 0);
    chkIdle("R7");
  endtask

  task automatic testFill(input logic [ADDR_W-1:0] a, input logic fs, input logic shared,
                          input int waitCycles, input bit pokeBusy);
    logic [ADDR_W-1:0] expAddr;
    expAddr = a & ALIGN_MASK;
    acceptHint(a, fs, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    // R3: request with aligned address
    chk(busReq == 1'b1, "R3", "busReq raised", 64'(busReq), 1);
    chk(lineAddr == expAddr, "R3", "aligned lineAddr", 64'(lineAddr), 64'(expAddr));
    chk(hintReady == 1'b0, "R8", "not ready while fetching", 64'(hintReady), 0);
    chk({hintDone, fillWe} == 2'b0, "R9", "no early done", 64'({hintDone, fillWe}), 0);
    if (pokeBusy) begin
      hintValid = 1'b1; hintAddr = 32'h7777_7740; lineResident = 1'b1;
    end
    for (int i = 0; i < waitCycles; i++) begin
      @(negedge clk);
      chk(busReq == 1'b1, "R10", "busReq held", 64'(busReq), 1);
      chk(lineAddr == expAddr, "R10", "lineAddr held", 64'(lineAddr), 64'(expAddr));
      chk(hintDone == 1'b0, "R8", "no done while busy", 64'(hintDone), 0);
    end
    busRespValid = 1'b1; busRespShared = shared; busRespData = lineFor(a);
    hintValid = 1'b0; lineResident = 1'b0;
    @(posedge clk);
    @(negedge clk);
    busRespValid = 1'b0; busRespShared = ~shared; busRespData = '1;
    // R5 / R6 / R9: fill cycle
    chk(fillWe == 1'b1, "R5", "fillWe", 64'(fillWe), 1);
    chk(fillState == (shared ? 2'b01 : 2'b10), "R5", "fillState",
        64'(fillState), shared ? 64'd1 : 64'd2);
    chk(fillData == lineFor(a), "R5", "fillData", fillData[63:0], lineFor(a) ^ 64'h0 );
    chk(lineAddr == expAddr, "R5", "fill lineAddr", 64'(lineAddr), 64'(expAddr));
    chk({hintDone, refSet, lruTouch, tlbLruTouch} == 4'hF, "R6", "fill bookkeeping",
        64'({hintDone, refSet, lruTouch, tlbLruTouch}), 64'hF);
    chk(busReq == 1'b0, "R10", "busReq dropped", 64'(busReq), 0);
    @(negedge clk);
    chk(fillWe == 1'b0, "R5", "fillWe single", 64'(fillWe), 0);
    chk(hintDone == 1'b0, "R9", "done single", 64'(hintDone), 0);
    chkIdle(pokeBusy ? "R8" : "R9");
    @(negedge clk);
    chkIdle(pokeBusy ? "R8" : "R9");
  endtask

  task automatic testStrayResp();
    @(negedge clk);
    busRespValid = 1'b1; busRespShared = 1'b1; busRespData = {(LINE_W/32){32'hDEADBEEF}};
    @(negedge clk);
    busRespValid = 1'b0; busRespShared = 1'b0;
    // R10: stray response ignored
    chkIdle("R10");
    @(negedge clk);
    chkIdle("R10");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chkIdle("R1");
    rstN = 1'b1;
    @(negedge clk);
    chkIdle("R1");

    // R4: each failing condition alone
    testNoop(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    testNoop(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    testNoop(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    testNoop(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    testNoop(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);   // R2 store form also no-op

    testResident(1'b0);                      // R7
    testResident(1'b1);                      // R2 store form on resident line

    testFill(32'h1234_567C, 1'b0, 1'b0, 0, 1'b0);  // R5 exclusive, immediate response
    testFill(32'h0ABC_0011, 1'b0, 1'b1, 3, 1'b0);  // R5 shared, delayed
    testFill(32'h1234_567C, 1'b1, 1'b0, 0, 1'b0);  // R2 store form, same as first
    testFill(32'h0ABC_0011, 1'b1, 1'b1, 3, 1'b0);  // R2 store form, shared
    testFill(32'h5555_00E4, 1'b0, 1'b0, 4, 1'b1);  // R8 hint held while busy
    testStrayResp();                               // R10
    testFill(32'h0000_1FFF, 1'b0, 1'b0, 1, 1'b0);  // R10 fresh data after stray

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule